// File: doc/BRIEF.md
# Receive Frame Statistics Counters

This block keeps the running statistics of a receive path. The frame checking logic upstream reports one result per finished frame: accepted (with the frame length in bytes, CRC included), discarded, or discarded because the frame buffer overflowed. From these results the block keeps four 64-bit frame counters and one 64-bit count of the bytes that were received correctly. The four frame counters are total, correct, discarded and overflow-discarded. It also holds two sticky overflow flags and the receive configuration registers that the checking logic uses.

Software reaches the block over a simple 32-bit register bus. The live counters keep changing while traffic flows. For that reason software never reads them directly. A strobe command copies every live counter into its readable shadow register in one cycle. Software then reads the low and high words of each shadow at leisure, and all the values it sees come from the same instant. A second command returns the live counters to zero.

Top module: `rx_stat_counters`

## Requirements
- R1: After reset every counter word, the status register, the enable, error-mask and filter-mode registers read zero. The minimum-length register reads 64 and the maximum-length register reads 1526.
- R2: `frm_result` is encoded as 0 = no frame, 1 = accepted, 2 = discarded, 3 = discarded on overflow. Any nonzero code adds one to the total count. Code 1 adds one to the correct count. Codes 2 and 3 each add one to the discarded count. Code 3 also adds one to the overflow-discarded count. Total therefore always equals correct plus discarded.
- R3: Code 1 adds `frm_len` to the byte count. No other code changes the byte count.
- R4: Writing 0x01 in bits 7:0 of the command register (offset 0x2C) copies all five live counters into the shadow registers in one cycle. A frame result presented in the same cycle as that write is not included in the copy, but it is still counted live.
- R5: Between strobes the shadow registers do not change, whatever frames arrive.
- R6: Writing 0x02 to the command register sets all live counters to zero. A frame result in the same cycle is lost. The shadow registers keep their values.
- R7: Offsets 0x00, 0x04, 0x08 and 0x0C return bits 31:0 of the total, correct, discarded and overflow-discarded shadows. Offsets 0x10, 0x14, 0x18 and 0x1C return bits 63:32 of the same four, in the same order. Offset 0x3C returns the low word of the byte shadow and 0x40 returns its high word.
- R8: Status register at 0x28. Bit 0 is set by a pulse on `ovf_meta` and bit 1 is set by a pulse on `ovf_data`. Both bits stay set until any write to 0x28 clears them. A pulse in the same cycle as that write wins, and its bit stays set.
- R9: Configuration registers:
  - 0x20: enable, bit 0.
  - 0x24: error mask, bits 4:0.
  - 0x30: minimum length, bits 15:0.
  - 0x34: maximum length, bits 15:0.
  - 0x38: filter mode, bits 1:0.

  Each is writable, reads back only its own field, and drives its `cfg_*` output from the cycle after the write.
- R10: Reserved bits, the command register and unmapped offsets read zero. Command values other than 0x01 and 0x02 have no effect.
- R11: A read pulse on `reg_rd` returns its data on `reg_rdata` with `reg_rvalid` high exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_result | input | 2 | Per-frame result code, one cycle per frame |
| frm_len | input | 16 | Frame length in bytes including CRC, used with code 1 |
| ovf_meta | input | 1 | Metadata FIFO overflow pulse |
| ovf_data | input | 1 | Data FIFO overflow pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| cfg_enable | output | 1 | Receive enable |
| cfg_err_mask | output | 5 | Error mask |
| cfg_min_len | output | 16 | Minimum frame length |
| cfg_max_len | output | 16 | Maximum frame length |
| cfg_filter_mode | output | 2 | Address filter mode |

## Verification
Suppose a live counter takes the wrong increment or loses its reset. This only becomes visible at the ports after the next strobe, on the word that counter feeds. The bench therefore strobes after every traffic pattern and reads all ten counter words. It also reads them again before and after strobes to catch shadows that move on their own. Same-cycle collisions between a strobe or a clear and a frame would otherwise hide for a whole window, so the bench forces each one and checks the effect at the next strobe. Carry into the high words only appears after about 2^32 bytes. A long run of maximum-length frames drives the byte count across that boundary.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    typedef enum logic [1:0] {
        FR_NONE = 2'd0,
        FR_OK   = 2'd1,
        FR_DROP = 2'd2,
        FR_OVF  = 2'd3
    } frm_res_e;

    // counter slots
    localparam int CI_TOTAL = 0;
    localparam int CI_OK    = 1;
    localparam int CI_DROP  = 2;
    localparam int CI_OVF   = 3;
    localparam int CI_BYTES = 4;
    localparam int NCNT     = 5;

    // register offsets
    localparam logic [7:0] OFS_TOT_LO  = 8'h00;
    localparam logic [7:0] OFS_OK_LO   = 8'h04;
    localparam logic [7:0] OFS_DRP_LO  = 8'h08;
    localparam logic [7:0] OFS_OVF_LO  = 8'h0C;
    localparam logic [7:0] OFS_TOT_HI  = 8'h10;
    localparam logic [7:0] OFS_OK_HI   = 8'h14;
    localparam logic [7:0] OFS_DRP_HI  = 8'h18;
    localparam logic [7:0] OFS_OVF_HI  = 8'h1C;
    localparam logic [7:0] OFS_ENABLE  = 8'h20;
    localparam logic [7:0] OFS_MASK    = 8'h24;
    localparam logic [7:0] OFS_STATUS  = 8'h28;
    localparam logic [7:0] OFS_CMD     = 8'h2C;
    localparam logic [7:0] OFS_MINLEN  = 8'h30;
    localparam logic [7:0] OFS_MAXLEN  = 8'h34;
    localparam logic [7:0] OFS_MODE    = 8'h38;
    localparam logic [7:0] OFS_BYT_LO  = 8'h3C;
    localparam logic [7:0] OFS_BYT_HI  = 8'h40;

    localparam logic [7:0] CMD_SNAP = 8'h01;
    localparam logic [7:0] CMD_CLR  = 8'h02;

    localparam logic [15:0] MINLEN_RST = 16'd64;
    localparam logic [15:0] MAXLEN_RST = 16'd1526;

    typedef struct packed {
        logic        en;
        logic [4:0]  mask;
        logic [15:0] min_len;
        logic [15:0] max_len;
        logic [1:0]  mode;
    } rx_cfg_t;

    function automatic logic [31:0] word_of(input logic [63:0] v, input logic hi);
        return hi ? v[63:32] : v[31:0];
    endfunction

endpackage

// File: rtl/rxstat_cnt.sv
module rxstat_cnt #(
    parameter int W     = 64,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_val,
    input  logic             snap,
    output logic [W-1:0]     live_q,
    output logic [W-1:0]     snap_q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            live_q <= '0;
        else if (inc_en)
            live_q <= live_q + W'(inc_val);
    end

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (snap)
            snap_q <= live_q;
    end
endmodule

// File: rtl/rxstat_sticky.sv
module rxstat_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                q[b] <= 1'b0;
            else if (set[b])
                q[b] <= 1'b1;
            else if (clr)
                q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_stat_counters.sv
module rx_stat_counters
    import rxstat_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        frm_result,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              ovf_meta,
    input  logic              ovf_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              cfg_enable,
    output logic [4:0]        cfg_err_mask,
    output logic [15:0]       cfg_min_len,
    output logic [15:0]       cfg_max_len,
    output logic [1:0]        cfg_filter_mode
);
    localparam int NSTAT = 2;

    frm_res_e res;
    assign res = frm_res_e'(frm_result);

    logic [7:0] ofs;
    assign ofs = 8'(reg_addr);

    logic cmd_wr, do_snap, do_clr;
    assign cmd_wr  = reg_wr && (ofs == OFS_CMD);
    assign do_snap = cmd_wr && (reg_wdata[7:0] == CMD_SNAP);
    assign do_clr  = cmd_wr && (reg_wdata[7:0] == CMD_CLR);

    // increment enables and amounts per counter slot
    logic [NCNT-1:0]            inc_en;
    logic [NCNT-1:0][LEN_W-1:0] inc_val;

    always_comb begin
        inc_en           = '0;
        inc_en[CI_TOTAL] = (res != FR_NONE);
        inc_en[CI_OK]    = (res == FR_OK);
        inc_en[CI_DROP]  = (res == FR_DROP) || (res == FR_OVF);
        inc_en[CI_OVF]   = (res == FR_OVF);
        inc_en[CI_BYTES] = (res == FR_OK);
        for (int i = 0; i < NCNT; i++)
            inc_val[i] = (i == CI_BYTES) ? frm_len : LEN_W'(1);
    end

    logic [NCNT-1:0][CNT_W-1:0] live_q;
    logic [NCNT-1:0][CNT_W-1:0] snap_q;

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        rxstat_cnt #(.W(CNT_W), .INC_W(LEN_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .clr     (do_clr),
            .inc_en  (inc_en[i]),
            .inc_val (inc_val[i]),
            .snap    (do_snap),
            .live_q  (live_q[i]),
            .snap_q  (snap_q[i])
        );
    end

    logic [NSTAT-1:0] stat_q;
    rxstat_sticky #(.N(NSTAT)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set ({ovf_data, ovf_meta}),
        .clr (reg_wr && (ofs == OFS_STATUS)),
        .q   (stat_q)
    );

    // configuration registers
    rx_cfg_t cfg_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en      <= 1'b0;
            cfg_q.mask    <= '0;
            cfg_q.min_len <= MINLEN_RST;
            cfg_q.max_len <= MAXLEN_RST;
            cfg_q.mode    <= '0;
        end else if (reg_wr) begin
            case (ofs)
                OFS_ENABLE: cfg_q.en      <= reg_wdata[0];
                OFS_MASK:   cfg_q.mask    <= reg_wdata[4:0];
                OFS_MINLEN: cfg_q.min_len <= reg_wdata[15:0];
                OFS_MAXLEN: cfg_q.max_len <= reg_wdata[15:0];
                OFS_MODE:   cfg_q.mode    <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    assign cfg_enable      = cfg_q.en;
    assign cfg_err_mask    = cfg_q.mask;
    assign cfg_min_len     = cfg_q.min_len;
    assign cfg_max_len     = cfg_q.max_len;
    assign cfg_filter_mode = cfg_q.mode;

    // read path
    logic [31:0] rd_mux;
    always_comb begin
        case (ofs)
            OFS_TOT_LO: rd_mux = word_of(64'(snap_q[CI_TOTAL]), 1'b0);
            OFS_OK_LO:  rd_mux = word_of(64'(snap_q[CI_OK]),    1'b0);
            OFS_DRP_LO: rd_mux = word_of(64'(snap_q[CI_DROP]),  1'b0);
            OFS_OVF_LO: rd_mux = word_of(64'(snap_q[CI_OVF]),   1'b0);
            OFS_TOT_HI: rd_mux = word_of(64'(snap_q[CI_TOTAL]), 1'b1);
            OFS_OK_HI:  rd_mux = word_of(64'(snap_q[CI_OK]),    1'b1);
            OFS_DRP_HI: rd_mux = word_of(64'(snap_q[CI_DROP]),  1'b1);
            OFS_OVF_HI: rd_mux = word_of(64'(snap_q[CI_OVF]),   1'b1);
            OFS_BYT_LO: rd_mux = word_of(64'(snap_q[CI_BYTES]), 1'b0);
            OFS_BYT_HI: rd_mux = word_of(64'(snap_q[CI_BYTES]), 1'b1);
            OFS_ENABLE: rd_mux = {31'd0, cfg_q.en};
            OFS_MASK:   rd_mux = {27'd0, cfg_q.mask};
            OFS_STATUS: rd_mux = {30'd0, stat_q};
            OFS_MINLEN: rd_mux = {16'd0, cfg_q.min_len};
            OFS_MAXLEN: rd_mux = {16'd0, cfg_q.max_len};
            OFS_MODE:   rd_mux = {30'd0, cfg_q.mode};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_rdata  <= reg_rd ? DATA_W'(rd_mux) : '0;
        end
    end
endmodule

// File: rtl/rxstat_chk.sv
module rxstat_chk
    import rxstat_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_wr,
    input logic                       reg_rd,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [DATA_W-1:0]          reg_wdata,
    input logic                       reg_rvalid,
    input logic                       ovf_meta,
    input logic                       ovf_data,
    input logic [NCNT-1:0][CNT_W-1:0] live_q,
    input logic [NCNT-1:0][CNT_W-1:0] snap_q,
    input logic [1:0]                 stat_q
);
    logic cmd_w, stat_w;
    assign cmd_w  = reg_wr && (8'(reg_addr) == OFS_CMD);
    assign stat_w = reg_wr && (8'(reg_addr) == OFS_STATUS);

    AST_LIVE_SUM: assert property (@(posedge clk) disable iff (rst)
        live_q[CI_TOTAL] == live_q[CI_OK] + live_q[CI_DROP]); // R2

    AST_OVF_BOUND: assert property (@(posedge clk) disable iff (rst)
        live_q[CI_OVF] <= live_q[CI_DROP]); // R2

    AST_SNAP_SUM: assert property (@(posedge clk) disable iff (rst)
        snap_q[CI_TOTAL] == snap_q[CI_OK] + snap_q[CI_DROP]); // R4

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cmd_w && reg_wdata[7:0] == CMD_SNAP) |=> $stable(snap_q)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_w && reg_wdata[7:0] == CMD_CLR) |=> (live_q == '0)); // R6

    AST_META_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[0] && !stat_w) |=> stat_q[0]); // R8

    AST_DATA_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stat_q[1] && !stat_w) |=> stat_q[1]); // R8

    AST_STAT_SET: assert property (@(posedge clk) disable iff (rst)
        (ovf_meta && ovf_data) |=> (stat_q == 2'b11)); // R8

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid); // R11

    AST_NO_SPURIOUS_RV: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid); // R11
endmodule

bind rx_stat_counters rxstat_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .ovf_meta   (ovf_meta),
    .ovf_data   (ovf_data),
    .live_q     (live_q),
    .snap_q     (snap_q),
    .stat_q     (stat_q)
);

// File: tb/test_rx_stat_counters.sv
module test_rx_stat_counters;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  frm_result = 2'd0;
    logic [15:0] frm_len = 16'd0;
    logic        ovf_meta = 1'b0, ovf_data = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = 8'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        cfg_enable;
    logic [4:0]  cfg_err_mask;
    logic [15:0] cfg_min_len, cfg_max_len;
    logic [1:0]  cfg_filter_mode;

    always #4 clk = ~clk; // 125 MHz

    rx_stat_counters i_rx_stat_counters (
        .clk(clk), .rst(rst), .frm_result(frm_result), .frm_len(frm_len),
        .ovf_meta(ovf_meta), .ovf_data(ovf_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .cfg_enable(cfg_enable), .cfg_err_mask(cfg_err_mask),
        .cfg_min_len(cfg_min_len), .cfg_max_len(cfg_max_len),
        .cfg_filter_mode(cfg_filter_mode)
    );

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    // model: 0 total, 1 correct, 2 discarded, 3 ovf-discarded, 4 bytes
    longint unsigned mlive[5];
    longint unsigned msnap[5];

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (reg_rvalid) begin
            if (exp_q.size() == 0) begin
                check(reg_rdata, 32'hDEAD_BEEF, "R11 unexpected rvalid");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(reg_rdata, e, t);
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic void model_frame(input logic [1:0] r, input logic [15:0] l);
        if (r != 0) mlive[0]++;
        if (r == 1) begin mlive[1]++; mlive[4] += l; end
        if (r >= 2) mlive[2]++;
        if (r == 3) mlive[3]++;
    endfunction

    task automatic frame(input logic [1:0] r, input logic [15:0] l);
        @(negedge clk);
        frm_result = r; frm_len = l;
        model_frame(r, l);
        @(negedge clk);
        frm_result = 2'd0;
    endtask

    task automatic strobe();
        wr(8'h2C, 32'h1);
        for (int i = 0; i < 5; i++) msnap[i] = mlive[i];
    endtask

    task automatic rd_snap(input string tag);
        rd(8'h00, msnap[0][31:0],  {tag, " R7 total lo"});
        rd(8'h04, msnap[1][31:0],  {tag, " R7 correct lo"});
        rd(8'h08, msnap[2][31:0],  {tag, " R7 discard lo"});
        rd(8'h0C, msnap[3][31:0],  {tag, " R7 ovf lo"});
        rd(8'h10, msnap[0][63:32], {tag, " R7 total hi"});
        rd(8'h14, msnap[1][63:32], {tag, " R7 correct hi"});
        rd(8'h18, msnap[2][63:32], {tag, " R7 discard hi"});
        rd(8'h1C, msnap[3][63:32], {tag, " R7 ovf hi"});
        rd(8'h3C, msnap[4][31:0],  {tag, " R3 bytes lo"});
        rd(8'h40, msnap[4][63:32], {tag, " R3 bytes hi"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) begin mlive[i] = 0; msnap[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R10 unmapped / command reads
        rd_snap("R1 reset");
        rd(8'h28, 32'd0, "R1 status");
        rd(8'h20, 32'd0, "R1 enable");
        rd(8'h24, 32'd0, "R1 mask");
        rd(8'h30, 32'd64, "R1 minlen");
        rd(8'h34, 32'd1526, "R1 maxlen");
        rd(8'h38, 32'd0, "R1 mode");
        rd(8'h2C, 32'd0, "R10 command reads zero");
        rd(8'h44, 32'd0, "R10 unmapped 0x44");
        rd(8'h7C, 32'd0, "R10 unmapped 0x7C");

        // R2 R3 mixed traffic, shadows stay until strobe (R5)
        frame(2'd1, 16'd100); frame(2'd1, 16'd60); frame(2'd2, 16'd999);
        frame(2'd3, 16'd77);  frame(2'd2, 16'd5);  frame(2'd1, 16'd1500);
        frame(2'd0, 16'd400);
        rd(8'h00, 32'd0, "R5 no strobe yet");
        strobe();
        rd_snap("R2 R4 first strobe");

        // R5 more traffic, reads unchanged
        frame(2'd3, 16'd1); frame(2'd1, 16'd64);
        rd_snap("R5 hold");
        strobe();
        rd_snap("R2 second strobe");

        // R4 strobe and frame in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'h1;
        frm_result = 2'd1; frm_len = 16'd200;
        for (int i = 0; i < 5; i++) msnap[i] = mlive[i];
        model_frame(2'd1, 16'd200);
        @(negedge clk);
        reg_wr = 1'b0; frm_result = 2'd0;
        rd_snap("R4 same-cycle excluded");
        strobe();
        rd_snap("R4 counted live");

        // R10 unknown command no effect
        wr(8'h2C, 32'h5);
        wr(8'h2C, 32'h102);  // bits 7:0 = 0x02 -> clear? no: 0x02 in low byte is clear
        for (int i = 0; i < 5; i++) mlive[i] = 0;
        frame(2'd2, 16'd0);
        wr(8'h2C, 32'h7);
        strobe();
        rd_snap("R10 R6 unknown command");

        // R6 clear with frame in same cycle; shadow keeps
        frame(2'd1, 16'd300);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'h2;
        frm_result = 2'd3;
        for (int i = 0; i < 5; i++) mlive[i] = 0;
        @(negedge clk);
        reg_wr = 1'b0; frm_result = 2'd0;
        rd_snap("R6 shadow kept");
        strobe();
        rd_snap("R6 cleared");

        // R9 configuration
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h30, 32'hABCD_1234);
        wr(8'h34, 32'h5555_05EE);
        wr(8'h38, 32'hFFFF_FFFE);
        @(negedge clk);
        check(32'(cfg_enable), 32'd1, "R9 cfg_enable");
        check(32'(cfg_err_mask), 32'h1F, "R9 cfg_err_mask");
        check(32'(cfg_min_len), 32'h1234, "R9 cfg_min_len");
        check(32'(cfg_max_len), 32'h05EE, "R9 cfg_max_len");
        check(32'(cfg_filter_mode), 32'd2, "R9 cfg_filter_mode");
        rd(8'h20, 32'd1, "R9 enable rb");
        rd(8'h24, 32'h1F, "R9 mask rb");
        rd(8'h30, 32'h1234, "R9 minlen rb");
        rd(8'h34, 32'h05EE, "R9 maxlen rb");
        rd(8'h38, 32'd2, "R9 mode rb");
        wr(8'h20, 32'h0);
        @(negedge clk);
        check(32'(cfg_enable), 32'd0, "R9 enable off");

        // R8 sticky status
        @(negedge clk); ovf_meta = 1'b1; @(negedge clk); ovf_meta = 1'b0;
        rd(8'h28, 32'd1, "R8 meta sticky");
        @(negedge clk); ovf_data = 1'b1; @(negedge clk); ovf_data = 1'b0;
        rd(8'h28, 32'd3, "R8 both sticky");
        wr(8'h28, 32'h0);
        rd(8'h28, 32'd0, "R8 write clears");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'hFFFF_FFFF; ovf_data = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ovf_data = 1'b0;
        rd(8'h28, 32'd2, "R8 set wins over clear");

        // R7 carry into high word of byte count
        wr(8'h2C, 32'h2);
        for (int i = 0; i < 5; i++) mlive[i] = 0;
        @(negedge clk);
        frm_result = 2'd1; frm_len = 16'hFFFF;
        for (int k = 0; k < 65540; k++) begin
            model_frame(2'd1, 16'hFFFF);
            @(negedge clk);
        end
        frm_result = 2'd0;
        strobe();
        rd_snap("R7 long run");

        repeat (4) @(negedge clk);
        check(32'(exp_q.size()), 32'd0, "R11 pending reads");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule